// File: doc/BRIEF.md
# Serial Audio-Control Register Interface

This block takes a three-wire control stream (an active-low enable, a serial clock and a data line) and turns it into a bank of nine audio-control registers: volume attenuation, volume gain, bass, treble, four speaker attenuators and an input switch. The three pins are brought into a fast system clock through two-flop synchronizers and their edges are found there, so the serial clock must run at least 16 times slower than the system clock.

Bits are shifted in, most significant first, on each rising serial clock edge seen while enable is low. When enable rises, the byte is kept only if exactly eight such edges were counted; any other count throws the byte away, which guards against glitches on the clock wire. A kept byte whose top bit is 0 chooses which register the following data bytes go to. A kept byte whose top bit is 1 writes its low seven bits into the chosen register. Every register write raises a one-cycle strobe together with the register index. Mute flags for the four speakers and for the input switch are decoded from the stored values.

Top module: `acp_serial_ctl`

## Requirements
- R1: While `rst` is high and after it falls, the registers hold these 7-bit values: volume attenuation 0x3F, volume gain 0x00, bass 0x1F, treble 0x0F, all four speakers 0x3F, switch 0x07. All speaker mute flags and the switch mute flag are 1, and `wr_stb_o` is 0.
- R2: A select byte (bit 7 = 0) followed by a data byte (bit 7 = 1), each framed with exactly eight clocks, writes data bits [6:0] into the register picked by select bits [6:3]: 000x volume attenuation (index 0), 100x volume gain (1), 010x bass (2), 110x treble (3), 001x right-front (4), 101x right-rear (5), 011x left-front (6), 1110 left-rear (7), 1111 switch (8).
- R3: A byte framed with fewer than eight serial clock edges changes no register and produces no strobe.
- R4: A byte framed with more than eight edges, including counts of 16 or more, changes no register and produces no strobe.
- R5: A data byte received after reset, before any select byte has been kept, is ignored.
- R6: A kept select stays in force, so several data bytes in a row all go to the same register.
- R7: A speaker mute flag (`spk_mute_o` bit 0 right-front, 1 right-rear, 2 left-front, 3 left-rear) is 1 exactly when bits [5:0] of that speaker register are all ones; bit 6 has no effect.
- R8: `sw_mute_o` is 1 exactly when switch register bits [2:0] are 111.
- R9: Each register write gives `wr_stb_o` high for exactly one system clock cycle, with `wr_idx_o` holding the index listed in R2; select bytes produce no strobe.
- R10: Serial clock edges while enable is high are neither shifted nor counted.
- R11: The first bit shifted in after enable falls becomes bit 7 of the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en_n | input | 1 | Serial frame enable, active low; rising edge commits the byte |
| ser_clk | input | 1 | Serial clock; data sampled on rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| vol_att_o | output | 7 | Stored volume attenuation value |
| vol_gain_o | output | 7 | Stored volume gain value |
| bass_o | output | 7 | Stored bass value |
| treble_o | output | 7 | Stored treble value |
| spk_rf_o | output | 7 | Stored right-front speaker attenuation |
| spk_rr_o | output | 7 | Stored right-rear speaker attenuation |
| spk_lf_o | output | 7 | Stored left-front speaker attenuation |
| spk_lr_o | output | 7 | Stored left-rear speaker attenuation |
| in_sel_o | output | 7 | Stored input switch value |
| spk_mute_o | output | 4 | Speaker mute flags (RF, RR, LF, LR in bits 0..3) |
| sw_mute_o | output | 1 | Input switch mute flag |
| wr_stb_o | output | 1 | One-cycle pulse on each register write |
| wr_idx_o | output | 4 | Index of the register written |

## Verification
The bench aims at the edge count: frames of seven, nine and twenty-four clocks must all be dropped, and a counter that wrapped instead of saturating would wrongly accept the twenty-four-clock frame. It sends a data byte before any select to catch a bank that writes to a default register, and sends data bytes back to back after one select to catch a select that is cleared after use. Clock pulses with enable high are followed by a normal byte, so a design counting them would drop that byte. Mute decode is tested with bit 6 both set and clear, and with one low bit cleared.

// File: rtl/acp_ctl_pkg.sv
package acp_ctl_pkg;

    localparam int BYTE_W   = 8;
    localparam int DATA_W   = BYTE_W - 1;
    localparam int NUM_REGS = 9;
    localparam int IDX_W    = $clog2(NUM_REGS + 7);
    localparam int NUM_SPK  = 4;
    localparam int CNT_W    = $clog2(BYTE_W) + 1;
    localparam int SPK_BASE = 4;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [IDX_W-1:0] {
        REG_VATT   = 4'd0,
        REG_VGAIN  = 4'd1,
        REG_BASS   = 4'd2,
        REG_TREB   = 4'd3,
        REG_SPK_RF = 4'd4,
        REG_SPK_RR = 4'd5,
        REG_SPK_LF = 4'd6,
        REG_SPK_LR = 4'd7,
        REG_SWITCH = 4'd8
    } reg_id_e;

    typedef struct packed {
        logic  valid;
        byte_t bits;
    } frame_t;

    localparam logic [5:0] SPK_MUTE_PAT = 6'h3F;
    localparam logic [2:0] SW_MUTE_PAT  = 3'b111;

    function automatic reg_id_e decode_select(input byte_t b);
        reg_id_e r;
        unique case (b[6:4])
            3'b000:  r = REG_VATT;
            3'b100:  r = REG_VGAIN;
            3'b010:  r = REG_BASS;
            3'b110:  r = REG_TREB;
            3'b001:  r = REG_SPK_RF;
            3'b101:  r = REG_SPK_RR;
            3'b011:  r = REG_SPK_LF;
            default: r = b[3] ? REG_SWITCH : REG_SPK_LR;
        endcase
        return r;
    endfunction

    function automatic data_t reset_value(input int idx);
        data_t v;
        case (idx)
            0:       v = 7'h3F;
            1:       v = 7'h00;
            2:       v = 7'h1F;
            3:       v = 7'h0F;
            8:       v = 7'h07;
            default: v = 7'h3F;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/acp_pin_sync.sv
module acp_pin_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, sync_q, prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
                prev_q <= RST_VAL[g];
            end else begin
                meta_q <= pin_i[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign level_o[g] = sync_q;
        assign rise_o[g]  = sync_q & ~prev_q;
        assign fall_o[g]  = ~sync_q & prev_q;
    end
endmodule

// File: rtl/acp_framer.sv
module acp_framer
    import acp_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_level_i,
    input  logic   en_rise_i,
    input  logic   sclk_rise_i,
    input  logic   sdat_i,
    output frame_t frame_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(BYTE_W);

    byte_t             shift_q;
    logic [CNT_W-1:0]  cnt_q;
    frame_t            frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            cnt_q   <= '0;
            frame_q <= '0;
        end else begin
            frame_q.valid <= 1'b0;
            if (en_rise_i) begin
                frame_q.valid <= (cnt_q == CNT_GOOD);
                frame_q.bits  <= shift_q;
                cnt_q         <= '0;
            end else if (!en_level_i && sclk_rise_i) begin
                shift_q <= {shift_q[BYTE_W-2:0], sdat_i};
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign frame_o = frame_q;
endmodule

// File: rtl/acp_reg_bank.sv
module acp_reg_bank
    import acp_ctl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  frame_t                        frame_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o,
    output logic                          wr_stb_o,
    output idx_t                          wr_idx_o
);
    logic    sel_valid_q;
    reg_id_e sel_q;
    logic    is_data, do_write;

    assign is_data  = frame_i.bits[BYTE_W-1];
    assign do_write = frame_i.valid && is_data && sel_valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_valid_q <= 1'b0;
            sel_q       <= REG_VATT;
            wr_stb_o    <= 1'b0;
            wr_idx_o    <= '0;
        end else begin
            wr_stb_o <= do_write;
            if (do_write) wr_idx_o <= sel_q;
            if (frame_i.valid && !is_data) begin
                sel_valid_q <= 1'b1;
                sel_q       <= decode_select(frame_i.bits);
            end
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_o[g] <= reset_value(g);
            else if (do_write && (sel_q == reg_id_e'(g)))
                regs_o[g] <= frame_i.bits[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/acp_serial_ctl.sv
module acp_serial_ctl
    import acp_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_en_n,
    input  logic                ser_clk,
    input  logic                ser_dat,
    output logic [DATA_W-1:0]   vol_att_o,
    output logic [DATA_W-1:0]   vol_gain_o,
    output logic [DATA_W-1:0]   bass_o,
    output logic [DATA_W-1:0]   treble_o,
    output logic [DATA_W-1:0]   spk_rf_o,
    output logic [DATA_W-1:0]   spk_rr_o,
    output logic [DATA_W-1:0]   spk_lf_o,
    output logic [DATA_W-1:0]   spk_lr_o,
    output logic [DATA_W-1:0]   in_sel_o,
    output logic [NUM_SPK-1:0]  spk_mute_o,
    output logic                sw_mute_o,
    output logic                wr_stb_o,
    output logic [IDX_W-1:0]    wr_idx_o
);
    localparam int PIN_EN  = 0;
    localparam int PIN_CLK = 1;
    localparam int PIN_DAT = 2;

    logic [2:0] lvl, rise, fall;
    frame_t     frame;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    acp_pin_sync #(.W(3), .RST_VAL(3'b001)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .pin_i   ({ser_dat, ser_clk, ser_en_n}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    acp_framer framer_i (
        .clk         (clk),
        .rst         (rst),
        .en_level_i  (lvl[PIN_EN]),
        .en_rise_i   (rise[PIN_EN]),
        .sclk_rise_i (rise[PIN_CLK]),
        .sdat_i      (lvl[PIN_DAT]),
        .frame_o     (frame)
    );

    acp_reg_bank bank_i (
        .clk      (clk),
        .rst      (rst),
        .frame_i  (frame),
        .regs_o   (regs),
        .wr_stb_o (wr_stb_o),
        .wr_idx_o (wr_idx_o)
    );

    assign vol_att_o  = regs[REG_VATT];
    assign vol_gain_o = regs[REG_VGAIN];
    assign bass_o     = regs[REG_BASS];
    assign treble_o   = regs[REG_TREB];
    assign spk_rf_o   = regs[REG_SPK_RF];
    assign spk_rr_o   = regs[REG_SPK_RR];
    assign spk_lf_o   = regs[REG_SPK_LF];
    assign spk_lr_o   = regs[REG_SPK_LR];
    assign in_sel_o   = regs[REG_SWITCH];

    for (genvar s = 0; s < NUM_SPK; s++) begin : g_mute
        assign spk_mute_o[s] = (regs[SPK_BASE+s][5:0] == SPK_MUTE_PAT);
    end
    assign sw_mute_o = (regs[REG_SWITCH][2:0] == SW_MUTE_PAT);

    logic unused_fall;
    assign unused_fall = ^fall;
endmodule

// File: rtl/acp_serial_ctl_chk.sv
module acp_serial_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic [6:0] vol_att_o,
    input logic [6:0] spk_rf_o,
    input logic [6:0] in_sel_o,
    input logic [3:0] spk_mute_o,
    input logic       sw_mute_o,
    input logic       wr_stb_o,
    input logic [3:0] wr_idx_o
);
    p_stb_single_r9: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);

    p_idx_range_r9: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> (wr_idx_o <= 4'd8));

    p_att_change_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(vol_att_o) |-> (wr_stb_o && wr_idx_o == 4'd0));

    p_rf_change_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(spk_rf_o) |-> (wr_stb_o && wr_idx_o == 4'd4));

    p_sw_change_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(in_sel_o) |-> (wr_stb_o && wr_idx_o == 4'd8));

    p_mute_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(spk_mute_o[0]) |-> (wr_stb_o && wr_idx_o == 4'd4));

    p_swmute_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_mute_o) |-> (wr_stb_o && wr_idx_o == 4'd8));

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vol_att_o == 7'h3F && in_sel_o == 7'h07
                        && spk_mute_o == 4'hF && !wr_stb_o));
endmodule

bind acp_serial_ctl acp_serial_ctl_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .vol_att_o  (vol_att_o),
    .spk_rf_o   (spk_rf_o),
    .in_sel_o   (in_sel_o),
    .spk_mute_o (spk_mute_o),
    .sw_mute_o  (sw_mute_o),
    .wr_stb_o   (wr_stb_o),
    .wr_idx_o   (wr_idx_o)
);

// File: tb/acp_serial_ctl_tb_top.sv
module acp_serial_ctl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_en_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
    logic [6:0] vol_att, vol_gain, bass, treble, rf, rr, lf, lr, insel;
    logic [3:0] spk_mute;
    logic       sw_mute, wr_stb;
    logic [3:0] wr_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int stb_cnt = 0;
    int stb_wide = 0;
    logic [3:0] last_idx = '0;
    logic prev_stb = 1'b0;
    int cyc = 0;

    always #4 clk = ~clk;

    acp_serial_ctl dut_i (
        .clk(clk), .rst(rst), .ser_en_n(ser_en_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .vol_att_o(vol_att), .vol_gain_o(vol_gain), .bass_o(bass), .treble_o(treble),
        .spk_rf_o(rf), .spk_rr_o(rr), .spk_lf_o(lf), .spk_lr_o(lr), .in_sel_o(insel),
        .spk_mute_o(spk_mute), .sw_mute_o(sw_mute), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx)
    );

    // strobe monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            stb_cnt++;
            last_idx = wr_idx;
            if (prev_stb) stb_wide++;
        end
        prev_stb = wr_stb;
    end

    // sel byte, data byte, expected register index, expected stored value
    localparam logic [26:0] VEC [9] = '{
        {8'h05, 8'hA5, 4'd0, 7'h25},
        {8'h40, 8'h89, 4'd1, 7'h09},
        {8'h2C, 8'h93, 4'd2, 7'h13},
        {8'h61, 8'h8C, 4'd3, 7'h0C},
        {8'h1F, 8'h92, 4'd4, 7'h12},
        {8'h50, 8'hC5, 4'd5, 7'h45},
        {8'h3A, 8'h81, 4'd6, 7'h01},
        {8'h72, 8'hB6, 4'd7, 7'h36},
        {8'h7D, 8'h83, 4'd8, 7'h03}
    };

    function automatic logic [6:0] reg_by_idx(input logic [3:0] i);
        case (i)
            4'd0: return vol_att;  4'd1: return vol_gain; 4'd2: return bass;
            4'd3: return treble;   4'd4: return rf;       4'd5: return rr;
            4'd6: return lf;       4'd7: return lr;       default: return insel;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int nclk);
        ser_en_n = 1'b0;
        wait_cyc(8);
        for (int i = 0; i < nclk; i++) begin
            ser_dat = (i < 8) ? b[7-i] : 1'b0;
            wait_cyc(8);
            ser_clk = 1'b1;
            wait_cyc(8);
            ser_clk = 1'b0;
        end
        wait_cyc(8);
        ser_en_n = 1'b1;
        wait_cyc(16);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                summary();
            end
        end
    end

    initial begin
        int base;
        wait_cyc(4);
        check("R1 vatt in reset", vol_att, 7'h3F);
        rst = 1'b0;
        wait_cyc(3);
        // R1 defaults
        check("R1 vatt", vol_att, 7'h3F);
        check("R1 vgain", vol_gain, 7'h00);
        check("R1 bass", bass, 7'h1F);
        check("R1 treble", treble, 7'h0F);
        check("R1 spk", {rf, rr, lf, lr}, {4{7'h3F}});
        check("R1 switch", insel, 7'h07);
        check("R1 mute flags", {spk_mute, sw_mute}, 5'h1F);
        check("R1 no strobe", stb_cnt, 0);

        // R5: data before any select ignored
        send(8'h80, 8);
        check("R5 no strobe", stb_cnt, 0);
        check("R5 vatt unchanged", vol_att, 7'h3F);
        check("R5 switch unchanged", insel, 7'h07);

        // R2/R9/R11 table walk
        for (int v = 0; v < 9; v++) begin
            base = stb_cnt;
            send(VEC[v][26:19], 8);
            check("R9 select gives no strobe", stb_cnt, base);
            send(VEC[v][18:11], 8);
            check("R2/R11 stored value", reg_by_idx(VEC[v][10:7]), VEC[v][6:0]);
            check("R9 one strobe", stb_cnt, base + 1);
            check("R9 strobe index", last_idx, VEC[v][10:7]);
        end
        check("R9 strobe width", stb_wide, 0);
        check("R7 rf unmuted", spk_mute[0], 1'b0);
        check("R7 lr muted flag clear", spk_mute[3], 1'b0);
        check("R8 switch unmuted", sw_mute, 1'b0);

        // R3/R4: wrong clock counts
        send(8'h10, 8);
        base = stb_cnt;
        send(8'hFF, 7);
        check("R3 short frame rf", rf, 7'h12);
        check("R3 short frame strobe", stb_cnt, base);
        send(8'hFF, 9);
        check("R4 long frame rf", rf, 7'h12);
        send(8'hFF, 24);
        check("R4 24-clock frame rf", rf, 7'h12);
        check("R4 long frames strobe", stb_cnt, base);

        // R6/R7: select persists, mute decode
        send(8'hFF, 8);
        check("R6 first data", rf, 7'h7F);
        check("R7 mute with bit6 set", spk_mute[0], 1'b1);
        send(8'hBF, 8);
        check("R6 second data", rf, 7'h3F);
        check("R7 mute with bit6 clear", spk_mute[0], 1'b1);
        send(8'hBE, 8);
        check("R7 unmute", spk_mute[0], 1'b0);
        check("R6 strobe count", stb_cnt, base + 3);

        // R8: switch mute
        send(8'h78, 8);
        send(8'h8F, 8);
        check("R8 switch value", insel, 7'h0F);
        check("R8 switch muted", sw_mute, 1'b1);
        send(8'h84, 8);
        check("R8 switch unmuted", sw_mute, 1'b0);

        // R10: clocks while enable high are ignored
        for (int i = 0; i < 5; i++) begin
            ser_dat = 1'b1;
            wait_cyc(8);
            ser_clk = 1'b1;
            wait_cyc(8);
            ser_clk = 1'b0;
        end
        wait_cyc(8);
        check("R10 no change while idle", insel, 7'h04);
        send(8'hC2, 8);
        check("R10 next byte still stored", insel, 7'h42);
        check("R9 strobe width end", stb_wide, 0);

        summary();
    end
endmodule